// File: doc/BRIEF.md
# Dual-Stream Issue Lag Controller

This block gates instruction issue for two half-instruction streams, called left and right, that advance in lockstep. Each stream owns a private countdown of lag cycles. A decoded half-instruction can add lag to its own side. That side then holds issue until its countdown reaches zero, and it resumes without reference to the other side. No arbitration or fixed priority exists between the sides. Two sides with equal lag resume in the same cycle.

Calls and returns preserve the lag state. A call pushes the current pair of lag values onto a small LIFO and starts the callee with both sides issuing. The matching return pops the pair back into the two countdowns. A call into a full stack, or a return from an empty stack, changes nothing on the stack and raises a sticky error flag.

Every clock is an issue clock. The outputs are one issue-valid per side and the two live lag values, so the exact cycle-by-cycle schedule can be observed.

Top module: `dual_lag_issue`

## Requirements
- R1: In the first cycle after a synchronous active-high reset, both lag outputs read 0, both issue outputs are 1, the stack is empty and the error flag is 0.
- R2: Each side's issue output is 1 exactly in the cycles where that side's lag output reads 0.
- R3: A non-zero lag decrements by one on every clock, and each side counts independently of the other.
- R4: When a side issues and its load input is 1, its lag output shows the 4-bit load value after the next edge. A value of 0 leaves the side issuing. Sides loaded with equal values resume in the same cycle, and with left 1 and right 2 the left side resumes one cycle before the right side.
- R5: A load that arrives while the side is stalled (lag non-zero) is ignored, and the countdown continues.
- R6: A call (call input 1) into a stack holding fewer than 8 entries pushes the current {left, right} lag pair and clears both lags after the edge, so both sides issue.
- R7: A return (return input 1, call input 0) into a non-empty stack pops the most recently pushed pair into the lags after the edge. This overrides loads and countdown, and entries come back in last-in first-out order.
- R8: A call while 8 entries are held, or a return while the stack is empty, leaves the stack contents unchanged. The lags then follow their normal load/countdown update, and the error flag becomes 1.
- R9: The error flag stays at 1 until the next reset clears it.
- R10: When call and return are both 1 in the same cycle, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Issue clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_left_i | input | 1 | Left decoded half-instruction adds lag |
| lag_left_i | input | 4 | Lag value added on the left side |
| ld_right_i | input | 1 | Right decoded half-instruction adds lag |
| lag_right_i | input | 4 | Lag value added on the right side |
| call_i | input | 1 | Call: save the lag pair |
| ret_i | input | 1 | Return: restore the lag pair |
| issue_left_o | output | 1 | Left side issues this cycle |
| issue_right_o | output | 1 | Right side issues this cycle |
| lag_left_o | output | 4 | Current left lag |
| lag_right_o | output | 4 | Current right lag |
| stack_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the controller with its defaults: 4-bit lag values and an 8-entry save stack. At this size every one of the 256 simultaneous left/right load pairs can be swept and followed to the end of its countdown, which covers equal lags, the 1-versus-2 stagger and the 15-cycle maximum. The stack is shallow enough to fill completely and drain in LIFO order, so both the overflow edge and the underflow edge are reached. The ordering cases around them are also covered: a call and a return in the same cycle, a return that overrides a countdown, and a load that is ignored while a side is stalled.

// File: rtl/dli_pkg.sv
package dli_pkg;

    typedef enum logic [2:0] {
        SRC_IDLE,
        SRC_RESTORE,
        SRC_CLEAR,
        SRC_LOAD,
        SRC_COUNT
    } lag_src_e;

    localparam int SIDES = 2;
    localparam int SIDE_RIGHT = 0;
    localparam int SIDE_LEFT  = 1;

endpackage

// File: rtl/dli_side.sv
module dli_side
    import dli_pkg::*;
#(
    parameter int LAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restore_i,
    input  logic [LAG_W-1:0] restore_val_i,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [LAG_W-1:0] load_val_i,
    output logic [LAG_W-1:0] lag_o,
    output logic             issue_o
);

    typedef struct packed {
        logic [LAG_W-1:0] lag;
    } side_st_t;

    side_st_t st_d, st_q;
    lag_src_e src;

    always_comb begin
        st_d = st_q;
        src  = SRC_IDLE;
        if (restore_i)
            src = SRC_RESTORE;
        else if (clear_i)
            src = SRC_CLEAR;
        else if (st_q.lag == '0 && load_i)
            src = SRC_LOAD;
        else if (st_q.lag != '0)
            src = SRC_COUNT;

        case (src)
            SRC_RESTORE: st_d.lag = restore_val_i;
            SRC_CLEAR:   st_d.lag = '0;
            SRC_LOAD:    st_d.lag = load_val_i;
            SRC_COUNT:   st_d.lag = st_q.lag - LAG_W'(1);
            default:     st_d.lag = st_q.lag;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lag_o   = st_q.lag;
    assign issue_o = (st_q.lag == '0);

    // R3: a stalled side counts down by exactly one
    a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
        (lag_o != '0 && !restore_i && !clear_i) |=> (lag_o == $past(lag_o) - LAG_W'(1)));

    // R5: a load presented while stalled never lands
    a_r5_stall_ignore: assert property (@(posedge clk) disable iff (rst)
        (lag_o > LAG_W'(1) && load_i && !restore_i && !clear_i && load_val_i != lag_o - LAG_W'(1))
        |=> (lag_o != $past(load_val_i)));

    // R4: a load while issuing takes effect on the next edge
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (issue_o && load_i && !restore_i && !clear_i) |=> (lag_o == $past(load_val_i)));

endmodule

// File: rtl/dli_save_stack.sv
module dli_save_stack #(
    parameter int ENTRY_W = 8,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [ENTRY_W-1:0] push_data_i,
    output logic [ENTRY_W-1:0] pop_data_o,
    output logic               push_ok_o,
    output logic               pop_ok_o,
    output logic               err_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
        logic [CW-1:0]                 cnt;
        logic                          err;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic    full, empty;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] wr_idx;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign top_idx = IW'(st_q.cnt - CW'(1));
    assign wr_idx  = IW'(st_q.cnt);

    always_comb begin
        st_d      = st_q;
        push_ok_o = push_i && !full;
        pop_ok_o  = pop_i && !push_i && !empty;

        if (push_ok_o) begin
            st_d.mem[wr_idx] = push_data_i;
            st_d.cnt         = st_q.cnt + CW'(1);
        end else if (pop_ok_o) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end

        if ((push_i && full) || (pop_i && !push_i && empty))
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pop_data_o = st_q.mem[top_idx];
    assign err_o      = st_q.err;

    // R8: overflow leaves the depth untouched and flags the error
    a_r8_full_push: assert property (@(posedge clk) disable iff (rst)
        (push_i && full) |=> (st_q.cnt == $past(st_q.cnt) && err_o));

    // R8: underflow leaves the depth untouched and flags the error
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty) |=> (st_q.cnt == '0 && err_o));

    // R9: the error flag never drops outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R7: a good pop shrinks the stack by one
    a_r7_pop_depth: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !empty) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

endmodule

// File: rtl/dual_lag_issue.sv
module dual_lag_issue
    import dli_pkg::*;
#(
    parameter int LAG_W = 4,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_left_i,
    input  logic [LAG_W-1:0] lag_left_i,
    input  logic             ld_right_i,
    input  logic [LAG_W-1:0] lag_right_i,
    input  logic             call_i,
    input  logic             ret_i,
    output logic             issue_left_o,
    output logic             issue_right_o,
    output logic [LAG_W-1:0] lag_left_o,
    output logic [LAG_W-1:0] lag_right_o,
    output logic             stack_err_o
);

    localparam int ENTRY_W = SIDES * LAG_W;

    logic [SIDES-1:0]            ld_vec;
    logic [SIDES-1:0][LAG_W-1:0] val_vec;
    logic [SIDES-1:0][LAG_W-1:0] lag_vec;
    logic [SIDES-1:0]            iss_vec;
    logic [ENTRY_W-1:0]          push_data, pop_data;
    logic                        push_ok, pop_ok, pop_req;

    assign ld_vec[SIDE_LEFT]   = ld_left_i;
    assign ld_vec[SIDE_RIGHT]  = ld_right_i;
    assign val_vec[SIDE_LEFT]  = lag_left_i;
    assign val_vec[SIDE_RIGHT] = lag_right_i;

    assign pop_req   = ret_i && !call_i;
    assign push_data = lag_vec;

    dli_save_stack #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (DEPTH)
    ) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (call_i),
        .pop_i       (pop_req),
        .push_data_i (push_data),
        .pop_data_o  (pop_data),
        .push_ok_o   (push_ok),
        .pop_ok_o    (pop_ok),
        .err_o       (stack_err_o)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dli_side #(
            .LAG_W (LAG_W)
        ) u_side (
            .clk           (clk),
            .rst           (rst),
            .restore_i     (pop_ok),
            .restore_val_i (pop_data[g*LAG_W +: LAG_W]),
            .clear_i       (push_ok),
            .load_i        (ld_vec[g]),
            .load_val_i    (val_vec[g]),
            .lag_o         (lag_vec[g]),
            .issue_o       (iss_vec[g])
        );
    end

    assign lag_left_o    = lag_vec[SIDE_LEFT];
    assign lag_right_o   = lag_vec[SIDE_RIGHT];
    assign issue_left_o  = iss_vec[SIDE_LEFT];
    assign issue_right_o = iss_vec[SIDE_RIGHT];

    // R6: an accepted call leaves both sides issuing
    a_r6_call_clears: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> (issue_left_o && issue_right_o));

    // R10: a simultaneous call and return never restores
    a_r10_call_wins: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |-> !pop_ok);

    // R2: issue matches a zero lag on each side
    a_r2_issue_match: assert property (@(posedge clk) disable iff (rst)
        (issue_left_o == (lag_left_o == '0)) && (issue_right_o == (lag_right_o == '0)));

endmodule

// File: tb/sim_dual_lag_issue.sv
module sim_dual_lag_issue;

    localparam int PERIOD = 10;
    localparam int W      = 4;
    localparam int D      = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_l = 1'b0, ld_r = 1'b0, call = 1'b0, ret = 1'b0;
    logic [W-1:0] vl = '0, vr = '0;
    logic         iss_l, iss_r, err;
    logic [W-1:0] lag_l, lag_r;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dual_lag_issue #(.LAG_W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst),
        .ld_left_i(ld_l), .lag_left_i(vl),
        .ld_right_i(ld_r), .lag_right_i(vr),
        .call_i(call), .ret_i(ret),
        .issue_left_o(iss_l), .issue_right_o(iss_r),
        .lag_left_o(lag_l), .lag_right_o(lag_r),
        .stack_err_o(err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pair(string req, int el, int er);
        chk(req, int'(lag_l), el);
        chk(req, int'(lag_r), er);
        chk(req, int'(iss_l), int'(el == 0));
        chk(req, int'(iss_r), int'(er == 0));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    function automatic int sat(int v);
        return (v < 0) ? 0 : v;
    endfunction

    initial begin
        do_reset();
        // R1: reset state
        chk_pair("R1", 0, 0);
        chk("R1", int'(err), 0);

        // R2 R3 R4: all simultaneous load pairs, followed to the end
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                ld_l = 1'b1; ld_r = 1'b1; vl = W'(a); vr = W'(b);
                tick();
                ld_l = 1'b0; ld_r = 1'b0;
                chk_pair("R4", a, b);
                for (int k = 2; k <= 16; k++) begin
                    tick();
                    chk_pair("R3", sat(a - (k - 1)), sat(b - (k - 1)));
                end
            end
        end

        // R4: the 1-versus-2 stagger
        ld_l = 1'b1; ld_r = 1'b1; vl = 4'd1; vr = 4'd2;
        tick();
        ld_l = 1'b0; ld_r = 1'b0;
        chk_pair("R4", 1, 2);
        tick();
        chk_pair("R4", 0, 1);
        tick();
        chk_pair("R4", 0, 0);

        // R5: load while stalled is ignored
        ld_l = 1'b1; vl = 4'd5;
        tick();
        chk("R5", int'(lag_l), 5);
        vl = 4'd12;
        tick();
        chk("R5", int'(lag_l), 4);
        ld_l = 1'b0;
        repeat (4) tick();
        chk_pair("R5", 0, 0);

        // R6 R7: call clears, return restores over a countdown
        ld_l = 1'b1; ld_r = 1'b1; vl = 4'd3; vr = 4'd7;
        tick();
        ld_l = 1'b0; ld_r = 1'b0;
        tick();
        chk_pair("R3", 2, 6);
        call = 1'b1;
        tick();
        call = 1'b0;
        chk_pair("R6", 0, 0);
        ld_l = 1'b1; ld_r = 1'b1; vl = 4'd1; vr = 4'd1;
        tick();
        ld_l = 1'b0; ld_r = 1'b0;
        chk_pair("R4", 1, 1);
        ret = 1'b1;
        tick();
        ret = 1'b0;
        chk_pair("R7", 2, 6);
        tick();
        chk_pair("R7", 1, 5);
        repeat (6) tick();

        // R10: call and return together perform only the call
        ld_l = 1'b1; ld_r = 1'b1; vl = 4'd4; vr = 4'd9;
        tick();
        ld_l = 1'b0; ld_r = 1'b0;
        call = 1'b1; ret = 1'b1;
        tick();
        call = 1'b0;
        chk_pair("R10", 0, 0);
        tick();
        ret = 1'b0;
        chk_pair("R10", 4, 9);
        chk("R10", int'(err), 0);
        repeat (10) tick();

        // R8 R9: return from empty stack
        ret = 1'b1; ld_l = 1'b1; vl = 4'd2;
        tick();
        ret = 1'b0; ld_l = 1'b0;
        chk_pair("R8", 2, 0);
        chk("R8", int'(err), 1);
        repeat (5) tick();
        chk("R9", int'(err), 1);
        do_reset();
        chk("R9", int'(err), 0);

        // R7 R8: fill, overflow, drain in LIFO order, underflow
        for (int i = 0; i < D; i++) begin
            ld_l = 1'b1; ld_r = 1'b1; vl = W'(i + 1); vr = W'(15 - i);
            tick();
            ld_l = 1'b0; ld_r = 1'b0;
            call = 1'b1;
            tick();
            call = 1'b0;
            chk_pair("R6", 0, 0);
        end
        call = 1'b1; ld_l = 1'b1; ld_r = 1'b1; vl = 4'd3; vr = 4'd3;
        tick();
        call = 1'b0; ld_l = 1'b0; ld_r = 1'b0;
        chk_pair("R8", 3, 3);
        chk("R8", int'(err), 1);
        for (int i = D - 1; i >= 0; i--) begin
            ret = 1'b1;
            tick();
            chk_pair("R7", i + 1, 15 - i);
        end
        tick();
        ret = 1'b0;
        chk_pair("R8", 0, 14);
        chk("R9", int'(err), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule